// File: doc/BRIEF.md
# Sequenced Register-Transfer Datapath

This block moves one data word from its input to its output through a fixed five-step register-transfer program. Three internal working registers (named a, b and c) are rewritten one at a time as a single-token controller walks through the program, one step per clock. The word is captured, inverted, bit-reversed, OR-merged with the captured copy, and finally presented at the output together with a one-cycle valid flag.

A user raises `start` for one clock while the block is idle and holds `xIn` steady until the edge that closes the first busy cycle. `busy` then stays high for five cycles. In the fifth cycle `zValid` is high and `zOut` carries the result, which is `x | reverse(~x)`. After that `zOut` keeps showing the result until the next run reaches its output step. The data width is a parameter, 2 bits by default, and any width of 2 or more works.

Top module: `seq_xfer_top`

## Requirements
- R1: While `rst` is high at a clock edge, and in the cycle after it, `busy` and `zValid` are 0 and `zOut` is all zeros.
- R2: A `start` that is high at an edge while `busy` is 0 makes `busy` high for exactly the next five cycles. `busy` is 0 in the cycle after those five.
- R3: At most one program step is active in any cycle. The steps run in the fixed order capture, invert, reverse, merge, output.
- R4: `xIn` is sampled only at the edge that ends the first busy cycle. Changes to `xIn` in later busy cycles do not affect the result.
- R5: In the output step, `zOut` equals `xIn | reverse(~xIn)`. Here reverse maps bit i to bit WIDTH-1-i. For WIDTH=2 the values are 00->11, 01->01, 10->10 and 11->11.
- R6: `zValid` is high for exactly one cycle per run, and that cycle is the fifth busy cycle.
- R7: Outside the output step, `zOut` holds the last produced result. This includes the first four busy cycles of a later run. Before the first run the held value is zero.
- R8: A `start` that is high while `busy` is 1 is ignored. The current run ends on schedule and no second run follows.
- R9: Asserting `rst` in the middle of a run aborts it. In the next cycle `busy`, `zValid` and `zOut` are all 0.
- R10: A working register changes only at the edge that ends the step naming it: a at capture, c at invert and merge, b at reverse, and the held output at the output step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Run request, sampled at a rising edge while idle |
| xIn | input | WIDTH | Data word to transform |
| zOut | output | WIDTH | Result word, held between runs |
| zValid | output | 1 | High in the output step of a run |
| busy | output | 1 | High while a run is in progress |

## Verification
The assertions assume that `rst` is a clean synchronous level and that `start` is either known or low at every edge. They make no assumption about `xIn`, because the design latches it only at the capture step. The stimulus drives every input at the falling edge, so each value is stable well before the rising edge that samples it. Runs where `xIn` is scrambled after capture, or where `start` is held high through a whole run, exercise the ignore paths without any overlap between runs.

// File: rtl/seq_xfer_pkg.sv
package seq_xfer_pkg;

  // Number of steps in the fixed register-transfer program.
  localparam int NUM_STEPS = 5;

  // Positions of each step in the controller ring (the order is behaviour).
  localparam int STEP_CAPTURE = 0;
  localparam int STEP_INVERT  = 1;
  localparam int STEP_REVERSE = 2;
  localparam int STEP_MERGE   = 3;
  localparam int STEP_EMIT    = 4;

  // Strobes from the controller to the datapath; at most one high per cycle.
  typedef struct packed {
    logic loadA;   // a <= x
    logic invC;    // c <= ~a
    logic revB;    // b <= bit-reversed c
    logic orC;     // c <= a | b
    logic emitZ;   // z <= c
  } stepStrobes_t;

endpackage

// File: rtl/seq_xfer_ctrl.sv
module seq_xfer_ctrl
  import seq_xfer_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         startReq,
  output stepStrobes_t strobes,
  output logic         busy
);

  localparam int LAST = NUM_STEPS - 1;

  // One-hot ring: a single token walks from capture to emit, then drops out.
  logic [NUM_STEPS-1:0] ringQ;
  logic [NUM_STEPS-1:0] ringD;
  logic                 idle;

  assign idle = ~(|ringQ);

  // Next-state: shift one place; inject a token only when the ring is empty.
  genvar gi;
  generate
    for (gi = 0; gi < NUM_STEPS; gi++) begin : g_ring
      if (gi == 0) begin : g_head
        assign ringD[gi] = idle & startReq;
      end else begin : g_body
        assign ringD[gi] = ringQ[gi-1];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      ringQ <= '0;
    end else begin
      ringQ <= ringD;
    end
  end

  assign busy = ~idle;

  always_comb begin
    strobes.loadA = ringQ[STEP_CAPTURE];
    strobes.invC  = ringQ[STEP_INVERT];
    strobes.revB  = ringQ[STEP_REVERSE];
    strobes.orC   = ringQ[STEP_MERGE];
    strobes.emitZ = ringQ[STEP_EMIT];
  end

  // R3: never more than one active step.
  a_r3_single_token: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ringQ));

  // R2: a start seen while idle puts the token on the capture step.
  a_r2_start_enters_capture: assert property (@(posedge clk) disable iff (rst)
    (startReq && idle) |=> (ringQ[STEP_CAPTURE] && $onehot(ringQ)));

  // R8: a start during a run neither restarts nor duplicates the token.
  a_r8_busy_start_ignored: assert property (@(posedge clk) disable iff (rst)
    (busy && !ringQ[LAST]) |=> ($onehot(ringQ) && !ringQ[STEP_CAPTURE]));

  // R2 / R6: the run ends right after the emit step.
  a_r6_end_after_emit: assert property (@(posedge clk) disable iff (rst)
    ringQ[LAST] |=> !busy);

endmodule

// File: rtl/seq_xfer_dp.sv
module seq_xfer_dp
  import seq_xfer_pkg::*;
#(
  parameter int WIDTH = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  stepStrobes_t       strobes,
  input  logic [WIDTH-1:0]   xIn,
  output logic [WIDTH-1:0]   zOut
);

  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] regA;
  logic [WIDTH-1:0] regB;
  logic [WIDTH-1:0] regC;
  logic [WIDTH-1:0] zHold;
  logic [WIDTH-1:0] cReversed;
  logic [WIDTH-1:0] cNext;
  logic             cLoad;

  // Full bit reversal of c: bit i takes bit MSB-i.
  genvar gb;
  generate
    for (gb = 0; gb < WIDTH; gb++) begin : g_rev
      assign cReversed[gb] = regC[MSB-gb];
    end
  endgenerate

  // c has two writers; the strobes are exclusive, invert takes precedence.
  always_comb begin
    cLoad = strobes.invC | strobes.orC;
    if (strobes.invC) begin
      cNext = ~regA;
    end else begin
      cNext = regA | regB;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      regA  <= '0;
      regB  <= '0;
      regC  <= '0;
      zHold <= '0;
    end else begin
      if (strobes.loadA) regA  <= xIn;
      if (strobes.revB)  regB  <= cReversed;
      if (cLoad)         regC  <= cNext;
      if (strobes.emitZ) zHold <= regC;
    end
  end

  // Live value during the emit step, held copy otherwise.
  assign zOut = strobes.emitZ ? regC : zHold;

  // R10: each register moves only at its own step.
  a_r10_a_only_at_capture: assert property (@(posedge clk) disable iff (rst)
    !strobes.loadA |=> $stable(regA));
  a_r10_b_only_at_reverse: assert property (@(posedge clk) disable iff (rst)
    !strobes.revB |=> $stable(regB));
  a_r10_c_only_at_invert_merge: assert property (@(posedge clk) disable iff (rst)
    !(strobes.invC || strobes.orC) |=> $stable(regC));
  // R7: the held output changes only at the emit step.
  a_r7_hold_between_runs: assert property (@(posedge clk) disable iff (rst)
    !strobes.emitZ |=> $stable(zHold));

  // R3: the controller never asks for two transfers at once.
  always_comb begin
    if (!rst) begin
      a_r3_strobes_exclusive: assert ($countones(strobes) <= 1);
    end
  end

endmodule

// File: rtl/seq_xfer_top.sv
module seq_xfer_top
  import seq_xfer_pkg::*;
#(
  parameter int WIDTH = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [WIDTH-1:0] xIn,
  output logic [WIDTH-1:0] zOut,
  output logic             zValid,
  output logic             busy
);

  stepStrobes_t strobes;

  seq_xfer_ctrl ctrl_i (
    .clk      (clk),
    .rst      (rst),
    .startReq (start),
    .strobes  (strobes),
    .busy     (busy)
  );

  seq_xfer_dp #(
    .WIDTH (WIDTH)
  ) dp_i (
    .clk     (clk),
    .rst     (rst),
    .strobes (strobes),
    .xIn     (xIn),
    .zOut    (zOut)
  );

  assign zValid = strobes.emitZ;

endmodule

// File: tb/seq_xfer_top_tb.sv
module seq_xfer_top_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int WIDTH      = 2;
  localparam int NVEC       = 4;
  // Each entry: {x[1:0], expected z[1:0]} per R5.
  localparam logic [3:0] VEC [NVEC] = '{4'b00_11, 4'b01_01, 4'b10_10, 4'b11_11};

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             start = 1'b0;
  logic [WIDTH-1:0] xIn = '0;
  logic [WIDTH-1:0] zOut;
  logic             zValid;
  logic             busy;

  int checks = 0;
  int errors = 0;
  logic [WIDTH-1:0] heldZ = '0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  seq_xfer_top #(.WIDTH(WIDTH)) dut_i (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .xIn    (xIn),
    .zOut   (zOut),
    .zValid (zValid),
    .busy   (busy)
  );

  task automatic checkVal(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One complete run. scramble: change x after capture (R4).
  // holdStart: keep start high for the whole run (R8).
  task automatic runSeq(input logic [WIDTH-1:0] xv, input logic [WIDTH-1:0] expZ,
                        input bit scramble, input bit holdStart);
    @(negedge clk);
    start = 1'b1;
    xIn   = xv;
    @(negedge clk);                        // busy cycle 1
    if (!holdStart) start = 1'b0;
    checkVal("R2 busy in cycle 1", busy, 1);
    for (int k = 2; k <= 4; k++) begin
      @(negedge clk);
      if (scramble) xIn = ~xv;
      checkVal("R6 zValid low before output step", zValid, 0);
      checkVal("R7 z holds previous result", zOut, heldZ);
      checkVal("R2 busy during run", busy, 1);
    end
    @(negedge clk);                        // busy cycle 5
    checkVal("R6 zValid in fifth cycle", zValid, 1);
    checkVal("R5 result value", zOut, expZ);
    checkVal("R2 busy in fifth cycle", busy, 1);
    heldZ = expZ;
    @(negedge clk);                        // first idle cycle
    checkVal("R2 busy drops after five cycles", busy, 0);
    checkVal("R6 zValid one cycle only", zValid, 0);
    checkVal("R7 z held after run", zOut, heldZ);
    start = 1'b0;
    if (holdStart) begin
      @(negedge clk);
      checkVal("R8 no second run from held start", busy, 0);
      checkVal("R8 no extra valid", zValid, 0);
    end
  endtask

  function automatic logic [WIDTH-1:0] refResult(input logic [WIDTH-1:0] v);
    logic [WIDTH-1:0] inv = ~v;
    logic [WIDTH-1:0] r;
    for (int i = 0; i < WIDTH; i++) r[i] = inv[WIDTH-1-i];
    return v | r;
  endfunction

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    checkVal("R1 busy under reset", busy, 0);
    checkVal("R1 zValid under reset", zValid, 0);
    checkVal("R1 z under reset", zOut, 0);
    rst = 1'b0;
    @(negedge clk);
    checkVal("R1 idle after reset", busy, 0);
    checkVal("R1 z zero after reset", zOut, 0);

    // Table walk: R5 for every input value.
    for (int v = 0; v < NVEC; v++) begin
      checkVal("R5 table matches reference", VEC[v][1:0], refResult(VEC[v][3:2]));
      runSeq(VEC[v][3:2], VEC[v][1:0], 1'b0, 1'b0);
    end

    // R4: x changed after capture does not affect the result.
    runSeq(2'b01, 2'b01, 1'b1, 1'b0);
    runSeq(2'b00, 2'b11, 1'b1, 1'b0);

    // R8: start held through a run is ignored.
    runSeq(2'b10, 2'b10, 1'b0, 1'b1);

    // R9: reset in the middle of a run.
    @(negedge clk);
    start = 1'b1;
    xIn   = 2'b01;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    checkVal("R9 busy cleared by reset", busy, 0);
    checkVal("R9 zValid cleared by reset", zValid, 0);
    checkVal("R9 z cleared by reset", zOut, 0);
    rst = 1'b0;
    heldZ = '0;
    repeat (6) begin
      @(negedge clk);
      checkVal("R9 aborted run stays idle", busy, 0);
    end

    // Back-to-back runs after abort still work.
    runSeq(2'b11, 2'b11, 1'b0, 1'b0);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule